// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits next to a small 8-bit processor core and decides, once per completed instruction, whether the core must enter an interrupt service routine and from which vector it must fetch the routine's address. It collects requests from four paths: the software-interrupt instruction, an active-low external interrupt pin, a group of timer event flags, and an optional port request. Each hardware request is qualified by its own enable and by the core's global mask bit. The software interrupt is taken whenever its instruction completes, whether or not the mask bit is set.

Hardware requests never cut an instruction short. They stay pending until the core pulses the boundary strobe. When a request is accepted, the block pulses a take strobe, presents the 16-bit vector fetch address and raises a request that sets the global mask bit. The block keeps its own copy of that mask bit. When the core returns from an interrupt, it reloads the copy through a restore input. All timer sources share one vector. A configuration input routes the port request onto the external-interrupt path.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high, `take_o` is 0 and `mask_o` is 1. On the first clock edge with `rst` low, `take_o` pulses with `vec_addr_o` = 0x1FFE, `set_mask_o` is 1 and `mask_o` is 1. Any latched external request is discarded by reset.
- R2: A hardware request is never taken on an edge where `boundary_i` is low; it stays pending. The decision made at a boundary edge appears on the registered outputs right after that same edge.
- R3: When `boundary_i` and `swi_exec_i` are both high, the block takes the software interrupt with vector 0x1FFC, whatever the value of `mask_o`.
- R4: A falling edge on `irq_n_i` passes through a two-stage synchronizer and is then latched. At a boundary, the latched request is taken with vector 0x1FFA if the mask is clear and `irq_en_i` is 1. Taking the IRQ vector clears the latch, and a rising edge does not set it.
- R5: A timer flag `tmr_flag_i[k]` counts as a request only when `tmr_en_i[k]` is also set. Any such request is taken with vector 0x1FF8 when the mask is clear. The block never clears a flag, so a flag that stays set is taken again once the mask is cleared.
- R6: When the mask is set, or when a source's enable is clear, that hardware source produces no take.
- R7: When several accepted requests compete, exactly one wins, in this fixed order: reset, then software interrupt, then IRQ/port, then timer. A higher vector address means higher priority.
- R8: Every take also pulses `set_mask_o` and leaves `mask_o` at 1, even if a restore arrives on the same edge.
- R9: A `mask_restore_i` pulse with no take on that edge loads `mask_o` from `mask_restore_val_i`.
- R10: When `port_sel_i` is 1, a high `port_req_i` acts as an IRQ request, is gated by `irq_en_i` and uses vector 0x1FFA. When `port_sel_i` is 0, `port_req_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction completed this cycle |
| swi_exec_i | input | 1 | The completing instruction is a software interrupt |
| irq_n_i | input | 1 | External interrupt pin, active low, asynchronous |
| irq_en_i | input | 1 | Enable for the IRQ/port path |
| port_sel_i | input | 1 | Configuration: route the port request into the IRQ path |
| port_req_i | input | 1 | Port interrupt request, level |
| tmr_flag_i | input | NUM_TMR | Timer status flags (capture, compare, overflow) |
| tmr_en_i | input | NUM_TMR | Per-flag timer interrupt enables |
| mask_restore_i | input | 1 | Reload the mask bit (return from interrupt) |
| mask_restore_val_i | input | 1 | Mask value to reload |
| take_o | output | 1 | Interrupt accepted strobe |
| vec_addr_o | output | 16 | Vector fetch address of the accepted source |
| set_mask_o | output | 1 | Request to set the global mask bit |
| mask_o | output | 1 | Current global mask bit |

## Verification
The bench sweeps every combination of these inputs and compares each boundary decision with a priority model: mask state, software interrupt, latched IRQ, IRQ enable, and all timer flag and enable patterns. Two faults are hard to see in simple tests:
- A design with the mask test placed on the software path would drop SWI while masked.
- A design with a wrong priority order would return the timer vector when IRQ is also pending.

Follow-up boundaries target the latch and the flags:
- A design that fails to clear the IRQ latch would take IRQ a second time.
- A design that cleared timer flags itself would miss the second timer take.

Directed cases cover the remaining corner cases. The port fold must work with and without the configuration bit. A restore that lands on the same edge as a take must lose. Boundary-free stretches must produce no take.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // Source code equals priority rank and vector offset/2.
  typedef enum logic [1:0] {
    SRC_TMR = 2'd0,
    SRC_IRQ = 2'd1,
    SRC_SWI = 2'd2,
    SRC_RST = 2'd3
  } ivc_src_e;

  function automatic logic [15:0] vec_of(input logic [15:0] base, input ivc_src_e src);
    return base + 16'({src, 1'b0});
  endfunction
endpackage

// File: rtl/ivc_irq_sync.sv
module ivc_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  input  logic clr_i,
  output logic lat_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              lat_q;
  logic              fall;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= pin_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign fall = last_q & ~sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      lat_q  <= 1'b0;
    end else begin
      last_q <= sync_q[STAGES-1];
      if (fall)       lat_q <= 1'b1;
      else if (clr_i) lat_q <= 1'b0;
    end
  end

  assign lat_o = lat_q;

  AST_LATCH_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_q) |-> !$past(sync_q[STAGES-1])); // R4
endmodule

// File: rtl/ivc_tmr_gate.sv
module ivc_tmr_gate #(
  parameter int NUM_TMR = 3
) (
  input  logic [NUM_TMR-1:0] flag_i,
  input  logic [NUM_TMR-1:0] en_i,
  output logic               req_o
);
  logic [NUM_TMR-1:0] hit;

  genvar k;
  generate
    for (k = 0; k < NUM_TMR; k++) begin : g_src
      assign hit[k] = flag_i[k] & en_i[k];
    end
  endgenerate

  assign req_o = |hit;
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
(
  input  logic     rst_pend_i,
  input  logic     boundary_i,
  input  logic     swi_i,
  input  logic     mask_i,
  input  logic     irq_req_i,
  input  logic     tmr_req_i,
  output logic     take_o,
  output ivc_src_e src_o
);
  always_comb begin
    take_o = 1'b0;
    src_o  = SRC_TMR;
    if (rst_pend_i) begin
      take_o = 1'b1;
      src_o  = SRC_RST;
    end else if (boundary_i) begin
      if (swi_i) begin
        take_o = 1'b1;
        src_o  = SRC_SWI;
      end else if (!mask_i && irq_req_i) begin
        take_o = 1'b1;
        src_o  = SRC_IRQ;
      end else if (!mask_i && tmr_req_i) begin
        take_o = 1'b1;
        src_o  = SRC_TMR;
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          NUM_TMR     = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_BASE    = 16'h1FF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boundary_i,
  input  logic               swi_exec_i,
  input  logic               irq_n_i,
  input  logic               irq_en_i,
  input  logic               port_sel_i,
  input  logic               port_req_i,
  input  logic [NUM_TMR-1:0] tmr_flag_i,
  input  logic [NUM_TMR-1:0] tmr_en_i,
  input  logic               mask_restore_i,
  input  logic               mask_restore_val_i,
  output logic               take_o,
  output logic [15:0]        vec_addr_o,
  output logic               set_mask_o,
  output logic               mask_o
);
  import ivc_pkg::*;

  localparam logic [15:0] VEC_TMR = VEC_BASE;
  localparam logic [15:0] VEC_IRQ = VEC_BASE + 16'd2;
  localparam logic [15:0] VEC_SWI = VEC_BASE + 16'd4;
  localparam logic [15:0] VEC_RST = VEC_BASE + 16'd6;

  logic     rst_pend_q;
  logic     mask_q;
  logic     take_q;
  logic     setm_q;
  logic [15:0] vec_q;

  logic     irq_lat;
  logic     irq_req;
  logic     tmr_req;
  logic     take_c;
  ivc_src_e src_c;
  logic     irq_clr;

  assign irq_clr = take_c && (src_c == SRC_IRQ);

  ivc_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_n_i (irq_n_i),
    .clr_i   (irq_clr),
    .lat_o   (irq_lat)
  );

  assign irq_req = irq_en_i & (irq_lat | (port_sel_i & port_req_i));

  ivc_tmr_gate #(.NUM_TMR(NUM_TMR)) u_tmr (
    .flag_i (tmr_flag_i),
    .en_i   (tmr_en_i),
    .req_o  (tmr_req)
  );

  ivc_arbiter u_arb (
    .rst_pend_i (rst_pend_q),
    .boundary_i (boundary_i),
    .swi_i      (swi_exec_i),
    .mask_i     (mask_q),
    .irq_req_i  (irq_req),
    .tmr_req_i  (tmr_req),
    .take_o     (take_c),
    .src_o      (src_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend_q <= 1'b1;
      mask_q     <= 1'b1;
      take_q     <= 1'b0;
      setm_q     <= 1'b0;
      vec_q      <= '0;
    end else begin
      rst_pend_q <= 1'b0;
      take_q     <= take_c;
      setm_q     <= take_c;
      if (take_c)               vec_q <= vec_of(VEC_BASE, src_c);
      if (take_c)               mask_q <= 1'b1;
      else if (mask_restore_i)  mask_q <= mask_restore_val_i;
    end
  end

  assign take_o     = take_q;
  assign set_mask_o = setm_q;
  assign vec_addr_o = vec_q;
  assign mask_o     = mask_q;

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ($past(boundary_i) || $past(rst_pend_q))); // R2
  AST_SWI_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(boundary_i && swi_exec_i && !rst_pend_q) |-> (take_o && vec_addr_o == VEC_SWI)); // R3
  AST_HW_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (take_o && (vec_addr_o == VEC_IRQ || vec_addr_o == VEC_TMR)) |-> !$past(mask_q)); // R6
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vec_addr_o == VEC_TMR || vec_addr_o == VEC_IRQ ||
                vec_addr_o == VEC_SWI || vec_addr_o == VEC_RST)); // R7
  AST_MASK_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (mask_o && set_mask_o)); // R8
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_restore_i) && !take_o) |-> (mask_o == $past(mask_restore_val_i))); // R9
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int NT = 3;
  localparam logic [15:0] V_TMR = 16'h1FF8;
  localparam logic [15:0] V_IRQ = 16'h1FFA;
  localparam logic [15:0] V_SWI = 16'h1FFC;
  localparam logic [15:0] V_RST = 16'h1FFE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary_i = 0, swi_exec_i = 0, irq_n_i = 1, irq_en_i = 0;
  logic port_sel_i = 0, port_req_i = 0;
  logic [NT-1:0] tmr_flag_i = '0, tmr_en_i = '0;
  logic mask_restore_i = 0, mask_restore_val_i = 0;
  logic take_o, set_mask_o, mask_o;
  logic [15:0] vec_addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NUM_TMR(NT)) dut_i (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .swi_exec_i(swi_exec_i),
    .irq_n_i(irq_n_i), .irq_en_i(irq_en_i), .port_sel_i(port_sel_i),
    .port_req_i(port_req_i), .tmr_flag_i(tmr_flag_i), .tmr_en_i(tmr_en_i),
    .mask_restore_i(mask_restore_i), .mask_restore_val_i(mask_restore_val_i),
    .take_o(take_o), .vec_addr_o(vec_addr_o), .set_mask_o(set_mask_o), .mask_o(mask_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expect take/no-take with vector; called after the decision edge.
  task automatic expect_take(input string req, input bit tk, input logic [15:0] v, input bit m_before);
    check({req, " take"}, 32'(take_o), 32'(tk));
    check({req, " set_mask"}, 32'(set_mask_o), 32'(tk));
    check({req, " mask"}, 32'(mask_o), 32'(tk ? 1'b1 : m_before));
    if (tk) check({req, " vector"}, 32'(vec_addr_o), 32'(v));
  endtask

  task automatic idle_inputs();
    boundary_i = 0; swi_exec_i = 0; irq_n_i = 1; irq_en_i = 0;
    port_sel_i = 0; port_req_i = 0; tmr_flag_i = '0; tmr_en_i = '0;
    mask_restore_i = 0; mask_restore_val_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1;
    @(negedge clk);
    check("R1 take in reset", 32'(take_o), 0);
    check("R1 mask in reset", 32'(mask_o), 1);
    rst = 0;
    @(negedge clk);
    expect_take("R1 reset vector", 1'b1, V_RST, 1'b1);
    @(negedge clk);
    check("R1 single pulse", 32'(take_o), 0);
  endtask

  task automatic restore(input bit m);
    mask_restore_i = 1; mask_restore_val_i = m;
    @(negedge clk);
    mask_restore_i = 0;
    check("R9 restore", 32'(mask_o), 32'(m));
    check("R2 no take on restore", 32'(take_o), 0);
  endtask

  task automatic boundary(input bit swi);
    boundary_i = 1; swi_exec_i = swi;
    @(negedge clk);
    boundary_i = 0; swi_exec_i = 0;
  endtask

  task automatic irq_fall();
    irq_n_i = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 pending without boundary", 32'(take_o), 0);
    end
    irq_n_i = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 pending without boundary", 32'(take_o), 0);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Exhaustive sweep of mask, SWI, IRQ latch, IRQ enable, timer flags/enables.
    for (int m = 0; m < 2; m++)
    for (int s = 0; s < 2; s++)
    for (int q = 0; q < 2; q++)
    for (int ie = 0; ie < 2; ie++)
    for (int fl = 0; fl < 8; fl++)
    for (int en = 0; en < 8; en++) begin
      bit irq_ok, tmr_ok, tk;
      logic [15:0] v;
      string tag;
      do_reset();
      restore(m[0]);
      irq_en_i = ie[0]; tmr_flag_i = fl[NT-1:0]; tmr_en_i = en[NT-1:0];
      if (q != 0) irq_fall();
      else begin
        @(negedge clk);
        check("R2 pending without boundary", 32'(take_o), 0);
      end
      irq_ok = (m == 0) && (q != 0) && (ie != 0);
      tmr_ok = (m == 0) && ((fl & en) != 0);
      tk = 1; v = V_TMR; tag = "R5 timer";
      if (s != 0)      begin v = V_SWI; tag = "R3 swi"; end
      else if (irq_ok) begin v = V_IRQ; tag = "R4 irq"; end
      else if (!tmr_ok) begin tk = 0; tag = "R6 gated"; end
      if ((s != 0 && (irq_ok || tmr_ok)) || (irq_ok && tmr_ok)) tag = {tag, " R7 priority"};
      boundary(s[0]);
      expect_take(tag, tk, v, m[0]);
      if (tk && v == V_IRQ) begin
        // R4: latch cleared by the take
        @(negedge clk);
        restore(1'b0);
        tmr_flag_i = '0;
        boundary(1'b0);
        expect_take("R4 latch cleared", 1'b0, V_IRQ, 1'b0);
      end else if (tk && v == V_TMR) begin
        // R5: flags stay set, timer taken again
        @(negedge clk);
        restore(1'b0);
        boundary(1'b0);
        expect_take("R5 flag persists", 1'b1, V_TMR, 1'b0);
      end
    end

    // R10: port folded into IRQ path
    do_reset(); restore(1'b0);
    port_sel_i = 1; port_req_i = 1; irq_en_i = 1;
    boundary(1'b0);
    expect_take("R10 port selected", 1'b1, V_IRQ, 1'b0);
    do_reset(); restore(1'b0);
    port_sel_i = 0; port_req_i = 1; irq_en_i = 1;
    boundary(1'b0);
    expect_take("R10 port not selected", 1'b0, V_IRQ, 1'b0);
    do_reset(); restore(1'b0);
    port_sel_i = 1; port_req_i = 1; irq_en_i = 0;
    boundary(1'b0);
    expect_take("R10 port disabled", 1'b0, V_IRQ, 1'b0);
    port_sel_i = 1; port_req_i = 1; irq_en_i = 1; tmr_flag_i = 3'b100; tmr_en_i = 3'b100;
    boundary(1'b0);
    expect_take("R10 R7 port over timer", 1'b1, V_IRQ, 1'b0);

    // R8: restore colliding with a take loses
    do_reset(); restore(1'b0);
    tmr_flag_i = 3'b010; tmr_en_i = 3'b010;
    mask_restore_i = 1; mask_restore_val_i = 0;
    boundary(1'b0);
    mask_restore_i = 0;
    expect_take("R8 take beats restore", 1'b1, V_TMR, 1'b0);

    // R1: reset discards a latched IRQ
    do_reset(); restore(1'b1);
    irq_en_i = 1; irq_fall();
    do_reset(); restore(1'b0);
    irq_en_i = 1;
    boundary(1'b0);
    expect_take("R1 latch cleared by reset", 1'b0, V_IRQ, 1'b0);

    // R2: pending timer waits many cycles for a boundary
    tmr_flag_i = 3'b001; tmr_en_i = 3'b001;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R2 wait for boundary", 32'(take_o), 0);
    end
    boundary(1'b0);
    expect_take("R2 taken at boundary", 1'b1, V_TMR, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule